// File: doc/BRIEF.md
# AXI ID Transaction Filter

The block sits beside a memory controller's AXI slave port and turns address handshakes into count increments for a performance counter bank. Each channel (read address, write address) is judged on its own: when valid and ready are both high, the transaction ID is compared against a programmed value, and only the bits the user chose to compare take part. A matching read raises the read increment, a matching write raises the write increment, and both can fire in the same cycle.

Beside the shared filter, a small set of counter lanes each carry their own ID filter and a selection register. The selection register picks, for each channel, whether that lane watches it and which port number it must come from. With the byte-mode input high, every increment is the transaction's byte total, (len+1) shifted left by size, instead of one per burst. The counters are outside the block; it only delivers per-cycle amounts, registered once.

Top module: `axid_txn_filter`

## Requirements
- R1: After reset all increment outputs are zero, every filter register is zero (all ID bits compared against zero) and every lane selection register holds 0x808, so no lane watches either channel.
- R2: A register write lands at address 0x30 for the shared filter, 0x50+16k for lane k's selection register and 0x54+16k for lane k's filter (k from 0); any other address changes nothing. A written value governs handshakes from the following cycle on.
- R3: A filter register holds the compare value in bits 15:0 and an ignore field in bits 31:16 (the inverse of the user's mask); ID bit i matches when ignore bit i is 1 or ID bit i equals compare bit i, and a transaction matches when all 16 bits match.
- R4: No increment appears for a channel unless its valid and ready were both high in the previous cycle.
- R5: The increment for a handshake appears on the outputs exactly one clock after the cycle of the handshake and lasts one cycle, so back-to-back handshakes give back-to-back increments.
- R6: The read and write channels are filtered independently; both increments can be non-zero in the same cycle.
- R7: With byte mode low, a matching transaction gives an increment of exactly 1.
- R8: With byte mode high, a matching transaction gives an increment of (len+1) << size, using that channel's len and size.
- R9: Lane selection register layout: bits 2:0 read port, bit 3 read-off (0 means the lane watches reads), bits 10:8 write port, bit 11 write-off. A lane's increment is the sum of the read amount (read watched, port equal, lane filter matches) and the write amount (same for writes).
- R10: Each lane judges IDs with its own filter register only; the shared filter has no effect on lane increments, and a lane's filter has no effect on the shared outputs.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| byte_mode | input | 1 | 1: increments are byte totals; 0: one per transaction |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | ADDR_W (8) | Register write address |
| reg_wdata | input | 32 | Register write data |
| ar_valid | input | 1 | Read address valid |
| ar_ready | input | 1 | Read address ready |
| ar_id | input | 16 | Read transaction ID |
| ar_port | input | 3 | Read source port number |
| ar_len | input | LEN_W (8) | Read burst length minus one |
| ar_size | input | SIZE_W (3) | Read log2 bytes per beat |
| aw_valid | input | 1 | Write address valid |
| aw_ready | input | 1 | Write address ready |
| aw_id | input | 16 | Write transaction ID |
| aw_port | input | 3 | Write source port number |
| aw_len | input | LEN_W (8) | Write burst length minus one |
| aw_size | input | SIZE_W (3) | Write log2 bytes per beat |
| rd_inc | output | INC_W (16) | Shared-filter read increment |
| wr_inc | output | INC_W (16) | Shared-filter write increment |
| lane_inc | output | NUM_LANES*CI_W (51) | Lane increments, lane k in bits [k*CI_W +: CI_W] |

## Verification
The assertions assume len and size are stable whenever valid is high, and that byte mode does not change in the cycle a handshake is judged; the bench only changes byte mode in a cycle with no handshake on either channel. They also assume the register write and a handshake that depends on it are in different cycles, which the bench keeps by giving every register write a cycle of its own. Port numbers are driven only within the 3-bit range, so a lane's port comparison is always defined.

// File: rtl/axid_filt_pkg.sv
package axid_filt_pkg;
  localparam int ID_W   = 16;
  localparam int REG_W  = 32;
  localparam int PORT_W = 3;

  localparam logic [7:0] SHARED_FILT_OFS = 8'h30;
  localparam logic [7:0] LANE_SEL_OFS    = 8'h50;
  localparam logic [7:0] LANE_FILT_OFS   = 8'h54;
  localparam int         LANE_STRIDE     = 16;

  // filter register: upper half ignore bits, lower half compare value
  typedef struct packed {
    logic [ID_W-1:0] ignore;
    logic [ID_W-1:0] cmp;
  } idfilt_t;

  // lane selection fields kept in storage (reserved bits dropped)
  typedef struct packed {
    logic              wr_off;
    logic [PORT_W-1:0] wr_port;
    logic              rd_off;
    logic [PORT_W-1:0] rd_port;
  } lane_sel_t;

  localparam lane_sel_t LANE_SEL_RESET = '{wr_off: 1'b1, wr_port: '0, rd_off: 1'b1, rd_port: '0};

  function automatic logic id_hit(idfilt_t f, logic [ID_W-1:0] id);
    return ((id ^ f.cmp) & ~f.ignore) == '0;
  endfunction

  function automatic lane_sel_t unpack_sel(logic [REG_W-1:0] w);
    lane_sel_t s;
    s.rd_port = w[2:0];
    s.rd_off  = w[3];
    s.wr_port = w[10:8];
    s.wr_off  = w[11];
    return s;
  endfunction
endpackage

// File: rtl/axid_filt_regs.sv
module axid_filt_regs
  import axid_filt_pkg::*;
#(
  parameter int NUM_LANES = 3,
  parameter int ADDR_W    = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_we,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [REG_W-1:0]  reg_wdata,
  output idfilt_t           shared_filt,
  output idfilt_t           lane_filt [NUM_LANES],
  output lane_sel_t         lane_sel  [NUM_LANES]
);
  localparam logic [ADDR_W-1:0] SHARED_A = ADDR_W'(SHARED_FILT_OFS);

  always_ff @(posedge clk) begin
    if (!rst_n) shared_filt <= '0;
    else if (reg_we && reg_addr == SHARED_A) shared_filt <= idfilt_t'(reg_wdata);
  end

  for (genvar k = 0; k < NUM_LANES; k++) begin : g_lane
    localparam logic [ADDR_W-1:0] SEL_A  = ADDR_W'(int'(LANE_SEL_OFS) + LANE_STRIDE * k);
    localparam logic [ADDR_W-1:0] FILT_A = ADDR_W'(int'(LANE_FILT_OFS) + LANE_STRIDE * k);

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        lane_filt[k] <= '0;
        lane_sel[k]  <= LANE_SEL_RESET;
      end else if (reg_we) begin
        if (reg_addr == FILT_A) lane_filt[k] <= idfilt_t'(reg_wdata);
        if (reg_addr == SEL_A)  lane_sel[k]  <= unpack_sel(reg_wdata);
      end
    end
  end
endmodule

// File: rtl/axid_chan_eval.sv
module axid_chan_eval
  import axid_filt_pkg::*;
#(
  parameter int LEN_W  = 8,
  parameter int SIZE_W = 3,
  parameter int INC_W  = LEN_W + (1 << SIZE_W)
) (
  input  logic              valid,
  input  logic              ready,
  input  logic [ID_W-1:0]   id,
  input  logic [LEN_W-1:0]  len,
  input  logic [SIZE_W-1:0] size,
  input  logic              byte_mode,
  input  idfilt_t           filt,
  output logic              hs,
  output logic              hit,
  output logic [INC_W-1:0]  amt
);
  function automatic logic [INC_W-1:0] burst_bytes(logic [LEN_W-1:0] l, logic [SIZE_W-1:0] s);
    logic [INC_W-1:0] beats;
    beats = INC_W'(l) + INC_W'(1);
    return beats << s;
  endfunction

  assign hs  = valid & ready;
  assign hit = hs & id_hit(filt, id);
  // amount a matching transaction would contribute
  assign amt = byte_mode ? burst_bytes(len, size) : INC_W'(1);
endmodule

// File: rtl/axid_lane.sv
module axid_lane
  import axid_filt_pkg::*;
#(
  parameter int INC_W = 16,
  parameter int CI_W  = INC_W + 1
) (
  input  logic              rd_hs,
  input  logic [ID_W-1:0]   rd_id,
  input  logic [PORT_W-1:0] rd_port,
  input  logic [INC_W-1:0]  rd_amt,
  input  logic              wr_hs,
  input  logic [ID_W-1:0]   wr_id,
  input  logic [PORT_W-1:0] wr_port,
  input  logic [INC_W-1:0]  wr_amt,
  input  idfilt_t           filt,
  input  lane_sel_t         sel,
  output logic [CI_W-1:0]   inc
);
  logic rd_take, wr_take;

  assign rd_take = rd_hs && !sel.rd_off && (rd_port == sel.rd_port) && id_hit(filt, rd_id);
  assign wr_take = wr_hs && !sel.wr_off && (wr_port == sel.wr_port) && id_hit(filt, wr_id);

  assign inc = (rd_take ? CI_W'(rd_amt) : '0) + (wr_take ? CI_W'(wr_amt) : '0);
endmodule

// File: rtl/axid_txn_filter.sv
module axid_txn_filter
  import axid_filt_pkg::*;
#(
  parameter int  LEN_W     = 8,
  parameter int  SIZE_W    = 3,
  parameter int  NUM_LANES = 3,
  parameter int  ADDR_W    = 8,
  localparam int INC_W     = LEN_W + (1 << SIZE_W),
  localparam int CI_W      = INC_W + 1
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      byte_mode,
  input  logic                      reg_we,
  input  logic [ADDR_W-1:0]         reg_addr,
  input  logic [REG_W-1:0]          reg_wdata,
  input  logic                      ar_valid,
  input  logic                      ar_ready,
  input  logic [ID_W-1:0]           ar_id,
  input  logic [PORT_W-1:0]         ar_port,
  input  logic [LEN_W-1:0]          ar_len,
  input  logic [SIZE_W-1:0]         ar_size,
  input  logic                      aw_valid,
  input  logic                      aw_ready,
  input  logic [ID_W-1:0]           aw_id,
  input  logic [PORT_W-1:0]         aw_port,
  input  logic [LEN_W-1:0]          aw_len,
  input  logic [SIZE_W-1:0]         aw_size,
  output logic [INC_W-1:0]          rd_inc,
  output logic [INC_W-1:0]          wr_inc,
  output logic [NUM_LANES*CI_W-1:0] lane_inc
);
  idfilt_t   shared_filt;
  idfilt_t   lane_filt [NUM_LANES];
  lane_sel_t lane_sel  [NUM_LANES];

  // named internal events, visible to the checker
  logic             rd_hs, rd_hit, wr_hs, wr_hit;
  logic [INC_W-1:0] rd_amt, wr_amt;
  logic [CI_W-1:0]  lane_inc_d [NUM_LANES];

  axid_filt_regs #(.NUM_LANES(NUM_LANES), .ADDR_W(ADDR_W)) u_regs (
    .clk, .rst_n, .reg_we, .reg_addr, .reg_wdata,
    .shared_filt, .lane_filt, .lane_sel
  );

  axid_chan_eval #(.LEN_W(LEN_W), .SIZE_W(SIZE_W), .INC_W(INC_W)) u_rd (
    .valid(ar_valid), .ready(ar_ready), .id(ar_id), .len(ar_len), .size(ar_size),
    .byte_mode, .filt(shared_filt), .hs(rd_hs), .hit(rd_hit), .amt(rd_amt)
  );

  axid_chan_eval #(.LEN_W(LEN_W), .SIZE_W(SIZE_W), .INC_W(INC_W)) u_wr (
    .valid(aw_valid), .ready(aw_ready), .id(aw_id), .len(aw_len), .size(aw_size),
    .byte_mode, .filt(shared_filt), .hs(wr_hs), .hit(wr_hit), .amt(wr_amt)
  );

  for (genvar k = 0; k < NUM_LANES; k++) begin : g_lane
    axid_lane #(.INC_W(INC_W), .CI_W(CI_W)) u_lane (
      .rd_hs, .rd_id(ar_id), .rd_port(ar_port), .rd_amt,
      .wr_hs, .wr_id(aw_id), .wr_port(aw_port), .wr_amt,
      .filt(lane_filt[k]), .sel(lane_sel[k]), .inc(lane_inc_d[k])
    );
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_inc   <= '0;
      wr_inc   <= '0;
      lane_inc <= '0;
    end else begin
      rd_inc <= rd_hit ? rd_amt : '0;
      wr_inc <= wr_hit ? wr_amt : '0;
      for (int k = 0; k < NUM_LANES; k++) lane_inc[k*CI_W +: CI_W] <= lane_inc_d[k];
    end
  end
endmodule

// File: rtl/axid_filt_chk.sv
module axid_filt_chk #(
  parameter int INC_W     = 16,
  parameter int CI_W      = 17,
  parameter int NUM_LANES = 3
) (
  input logic                      clk,
  input logic                      rst_n,
  input logic                      byte_mode,
  input logic                      rd_hs,
  input logic                      wr_hs,
  input logic                      rd_hit,
  input logic                      wr_hit,
  input logic [INC_W-1:0]          rd_inc,
  input logic [INC_W-1:0]          wr_inc,
  input logic [NUM_LANES*CI_W-1:0] lane_inc
);
  a_r4_rd_needs_handshake: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_hs |=> rd_inc == '0);

  a_r4_wr_needs_handshake: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_hs |=> wr_inc == '0);

  a_r3_miss_gives_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_hs && !rd_hit) |=> rd_inc == '0);

  a_r7_burst_is_one: assert property (@(posedge clk) disable iff (!rst_n)
    (!byte_mode && rd_hit) |=> rd_inc == INC_W'(1));

  a_r8_bytes_nonzero: assert property (@(posedge clk) disable iff (!rst_n)
    (byte_mode && wr_hit) |=> wr_inc != '0);

  a_r6_both_channels: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_hit && wr_hit) |=> (rd_inc != '0 && wr_inc != '0));

  a_r9_lanes_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !(rd_hs || wr_hs) |=> lane_inc == '0);
endmodule

bind axid_txn_filter axid_filt_chk #(.INC_W(INC_W), .CI_W(CI_W), .NUM_LANES(NUM_LANES)) u_chk (
  .clk(clk), .rst_n(rst_n), .byte_mode(byte_mode),
  .rd_hs(rd_hs), .wr_hs(wr_hs), .rd_hit(rd_hit), .wr_hit(wr_hit),
  .rd_inc(rd_inc), .wr_inc(wr_inc), .lane_inc(lane_inc)
);

// File: tb/axid_txn_filter_test.sv
module axid_txn_filter_test;
  localparam int LANES = 3;
  localparam int IW = 16;
  localparam int CW = 17;

  typedef struct packed {
    logic [IW-1:0] rd;
    logic [IW-1:0] wr;
    logic [CW-1:0] l0;
    logic [CW-1:0] l1;
    logic [CW-1:0] l2;
  } exp_t;

  logic clk = 1'b0, rst_n = 1'b0, byte_mode = 1'b0, reg_we = 1'b0;
  logic [7:0] reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic ar_valid = 0, ar_ready = 0, aw_valid = 0, aw_ready = 0;
  logic [15:0] ar_id = '0, aw_id = '0;
  logic [2:0] ar_port = '0, aw_port = '0, ar_size = '0, aw_size = '0;
  logic [7:0] ar_len = '0, aw_len = '0;
  logic [IW-1:0] rd_inc, wr_inc;
  logic [LANES*CW-1:0] lane_inc;

  int checks = 0, errors = 0;
  exp_t exp_q[$];
  string tag_q[$];

  // bench model of programmed state
  logic [31:0] m_shared = '0;
  logic [31:0] m_lf [LANES] = '{default: '0};
  logic [11:0] m_sel [LANES] = '{default: 12'h808};
  logic m_byte = 1'b0;

  axid_txn_filter uut (
    .clk, .rst_n, .byte_mode, .reg_we, .reg_addr, .reg_wdata,
    .ar_valid, .ar_ready, .ar_id, .ar_port, .ar_len, .ar_size,
    .aw_valid, .aw_ready, .aw_id, .aw_port, .aw_len, .aw_size,
    .rd_inc, .wr_inc, .lane_inc
  );

  always #10 clk = ~clk;

  function automatic bit m_hit(logic [31:0] f, logic [15:0] id);
    for (int i = 0; i < 16; i++)
      if (f[16+i] == 1'b0 && id[i] != f[i]) return 1'b0;
    return 1'b1;
  endfunction

  function automatic int m_amt(logic [7:0] len, logic [2:0] size);
    if (!m_byte) return 1;
    return (int'(len) + 1) * (1 << size);
  endfunction

  task automatic check(string tag, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  task automatic push_expect(string tag);
    exp_t e;
    int ln [LANES];
    bit rh, wh;
    rh = ar_valid && ar_ready;
    wh = aw_valid && aw_ready;
    e.rd = (rh && m_hit(m_shared, ar_id)) ? IW'(m_amt(ar_len, ar_size)) : '0;
    e.wr = (wh && m_hit(m_shared, aw_id)) ? IW'(m_amt(aw_len, aw_size)) : '0;
    for (int k = 0; k < LANES; k++) begin
      ln[k] = 0;
      if (rh && !m_sel[k][3] && ar_port == m_sel[k][2:0] && m_hit(m_lf[k], ar_id))
        ln[k] += m_amt(ar_len, ar_size);
      if (wh && !m_sel[k][11] && aw_port == m_sel[k][10:8] && m_hit(m_lf[k], aw_id))
        ln[k] += m_amt(aw_len, aw_size);
    end
    e.l0 = CW'(ln[0]); e.l1 = CW'(ln[1]); e.l2 = CW'(ln[2]);
    exp_q.push_back(e);
    tag_q.push_back(tag);
  endtask

  task automatic quiet_inputs();
    reg_we = 0; ar_valid = 0; ar_ready = 0; aw_valid = 0; aw_ready = 0;
  endtask

  task automatic beat(bit av, bit ar, logic [15:0] aid, logic [2:0] ap, logic [7:0] al, logic [2:0] as,
                      bit wv, bit wrd, logic [15:0] wid, logic [2:0] wp, logic [7:0] wl, logic [2:0] ws,
                      string tag);
    @(negedge clk);
    quiet_inputs();
    ar_valid = av; ar_ready = ar; ar_id = aid; ar_port = ap; ar_len = al; ar_size = as;
    aw_valid = wv; aw_ready = wrd; aw_id = wid; aw_port = wp; aw_len = wl; aw_size = ws;
    push_expect(tag);
  endtask

  task automatic reg_write(logic [7:0] a, logic [31:0] d, string tag);
    @(negedge clk);
    quiet_inputs();
    reg_we = 1; reg_addr = a; reg_wdata = d;
    push_expect(tag);
    if (a == 8'h30) m_shared = d;
    for (int k = 0; k < LANES; k++) begin
      if (a == 8'(8'h50 + 16*k)) m_sel[k] = {d[11:8], 4'b0000, d[3:0]};
      if (a == 8'(8'h54 + 16*k)) m_lf[k] = d;
    end
  endtask

  task automatic set_bytes(bit m, string tag);
    @(negedge clk);
    quiet_inputs();
    byte_mode = m;
    push_expect(tag);
    m_byte = m;
  endtask

  // monitor: compare each output cycle with the queued expectation
  initial begin
    exp_t e;
    string t;
    forever begin
      @(posedge clk);
      #5;
      if (exp_q.size() > 0) begin
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        check(t, "rd_inc", int'(rd_inc), int'(e.rd));
        check(t, "wr_inc", int'(wr_inc), int'(e.wr));
        check(t, "lane0", int'(lane_inc[0*CW +: CW]), int'(e.l0));
        check(t, "lane1", int'(lane_inc[1*CW +: CW]), int'(e.l1));
        check(t, "lane2", int'(lane_inc[2*CW +: CW]), int'(e.l2));
      end
    end
  end

  initial begin
    repeat (5000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=expired expected=done");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #5;
    check("R1", "rd_inc reset", int'(rd_inc), 0);
    check("R1", "wr_inc reset", int'(wr_inc), 0);
    check("R1", "lane_inc reset", int'(lane_inc != '0), 0);
    @(negedge clk);
    rst_n = 1;

    // R1: zero filter compares every bit with zero; lanes watch nothing
    beat(1,1,16'h0000,3'd0,8'd0,3'd0, 1,1,16'h0005,3'd0,8'd0,3'd0, "R1");
    // R4: valid without ready, ready without valid
    beat(1,0,16'h0000,3'd0,8'd0,3'd0, 0,1,16'h0000,3'd0,8'd0,3'd0, "R4");
    beat(0,1,16'h0000,3'd0,8'd0,3'd0, 1,0,16'h0000,3'd0,8'd0,3'd0, "R4");

    // R2/R3: compare upper 12 bits with 0x12A, ignore low nibble
    reg_write(8'h30, 32'h000F_12A0, "R2");
    beat(1,1,16'h12A7,3'd0,8'd0,3'd0, 1,1,16'h13A0,3'd0,8'd0,3'd0, "R3");
    // R6: both channels match in one cycle
    beat(1,1,16'h12AF,3'd0,8'd0,3'd0, 1,1,16'h12A0,3'd0,8'd0,3'd0, "R6");
    // R2: unmapped address must not open the filter
    reg_write(8'h34, 32'hFFFF_0000, "R2");
    beat(1,1,16'h0000,3'd0,8'd0,3'd0, 1,1,16'hFFFF,3'd0,8'd0,3'd0, "R2");
    // R5: back-to-back handshakes, alternating hits
    beat(1,1,16'h12A1,3'd0,8'd0,3'd0, 0,0,16'h0000,3'd0,8'd0,3'd0, "R5");
    beat(1,1,16'h22A1,3'd0,8'd0,3'd0, 1,1,16'h12A2,3'd0,8'd0,3'd0, "R5");
    beat(1,1,16'h12A3,3'd0,8'd0,3'd0, 0,0,16'h0000,3'd0,8'd0,3'd0, "R5");
    // R7: burst mode counts one whatever the length
    beat(1,1,16'h12A4,3'd0,8'd15,3'd3, 1,1,16'h12A5,3'd0,8'd255,3'd7, "R7");

    // R8: byte mode
    set_bytes(1'b1, "R8");
    beat(1,1,16'h12A1,3'd0,8'd3,3'd2, 1,1,16'h12A2,3'd0,8'd0,3'd0, "R8");
    beat(1,1,16'h12A6,3'd0,8'd255,3'd7, 1,1,16'h0000,3'd0,8'd7,3'd1, "R8");

    // R9/R10: lane programming
    reg_write(8'h50, 32'h0000_0802, "R9");   // lane0 reads from port 2
    reg_write(8'h54, 32'h0000_0055, "R10");  // lane0 exact ID 0x0055
    reg_write(8'h60, 32'h0000_0508, "R9");   // lane1 writes from port 5
    reg_write(8'h64, 32'hFFFF_0000, "R10");  // lane1 any ID
    reg_write(8'h70, 32'h0000_0101, "R9");   // lane2 both channels, port 1
    reg_write(8'h74, 32'h000F_12A0, "R10");
    set_bytes(1'b0, "R9");
    beat(1,1,16'h0055,3'd2,8'd0,3'd0, 0,0,16'h0000,3'd0,8'd0,3'd0, "R10");
    beat(1,1,16'h0055,3'd3,8'd0,3'd0, 1,1,16'h9999,3'd5,8'd0,3'd0, "R9");
    beat(1,1,16'h12A3,3'd1,8'd0,3'd0, 1,1,16'h12A4,3'd1,8'd0,3'd0, "R9");
    beat(1,1,16'h12A3,3'd0,8'd0,3'd0, 1,1,16'h12A4,3'd5,8'd0,3'd0, "R9");
    set_bytes(1'b1, "R8");
    beat(1,1,16'h12A3,3'd1,8'd1,3'd1, 1,1,16'h12A4,3'd1,8'd3,3'd0, "R8");
    beat(1,1,16'h0055,3'd2,8'd9,3'd3, 1,1,16'h0001,3'd5,8'd255,3'd7, "R9");

    repeat (3) beat(0,0,16'h0,3'd0,8'd0,3'd0, 0,0,16'h0,3'd0,8'd0,3'd0, "R4");
    repeat (3) @(negedge clk);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule